// File: doc/BRIEF.md
# Seven-Pin Bidirectional GPIO Port

This block is a memory-mapped general-purpose I/O port serving seven pads. Software sees three registers on a small synchronous bus: a direction register, an output latch, and a pin-level view. Each pad gets an output enable and an output value from the block, and returns an input level to it. Pad levels pass through a multi-stage synchronizer before they can be read.

The port readback and the latch readback are kept apart on purpose. A read of the pin view returns what the pads actually show. A read of the latch returns what the block is trying to drive. Because of this, read-modify-write code that works on the latch is not disturbed by loaded or externally driven pins. Three kinds of pin sit side by side. Ordinary pins have push-pull drivers. Pin 4 can only pull low. Pin 6 is usable only while an external clocking-mode input frees it. An analog-select mask, sampled at the pins, makes pins read as zero without affecting their drivers.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register reads 7'h7F (all inputs), the latch reads 7'h00, and every pad_oe bit is 0.
- R2: A write with bus_addr = 0 loads the direction register on that clock edge, and a read at address 0 returns it.
- R3: A write with bus_addr = 1 or bus_addr = 2 loads the output latch. A read at address 2 returns the latch contents whatever the pad levels are.
- R4: A read at address 1 returns the pad levels after two clock edges of synchronization. After only one edge it still shows the earlier level.
- R5: For an ordinary pin, direction bit 0 gives pad_oe = 1 with pad_out equal to the latch bit. Direction bit 1 gives pad_oe = 0.
- R6: Pin 4 is open-drain. Its pad_out is always 0. Its pad_oe is 1 only when its direction bit is 0 and its latch bit is 0.
- R7: While osc_io_en = 0, pin 6 never drives (pad_oe[6] = 0) and reads as 0 at address 1. While osc_io_en = 1, it behaves as an ordinary pin.
- R8: A pin whose ana_sel bit is 1 reads as 0 at address 1, except pins 4 and 6, which always stay digital. The mask 7'h2F, the power-up configuration, makes bits 5 and 3:0 read 0. The analog mask has no effect on pad_oe or pad_out.
- R9: Address 3 reads as 0, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 pin levels, 2 latch, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Combinational read data for bus_addr |
| ana_sel | input | 7 | Per-pin analog selection (1 = analog) |
| osc_io_en | input | 1 | 1 when the clocking mode frees pin 6 for general I/O |
| pad_in | input | 7 | Levels seen at the pads |
| pad_oe | output | 7 | Per-pin output driver enable |
| pad_out | output | 7 | Per-pin value presented to the driver |

## Verification
The assertions assume that bus_addr, bus_wr and bus_wdata hold steady around each rising edge. They also assume that pad_in is free of X, because the synchronizer checks compare stage values across edges. The bench keeps to these assumptions by changing every input only on the falling edge and by driving pad_in to a defined value from time zero. The analog-zero and gated-pin checks also assume that ana_sel and osc_io_en stay still between edges. The stimulus updates them on falling edges only, together with the pad pattern.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned GB_ADDR_W = 2;

   typedef enum logic [GB_ADDR_W-1:0] {
      GB_REG_DIR  = 2'd0,
      GB_REG_PIN  = 2'd1,
      GB_REG_OUT  = 2'd2,
      GB_REG_NONE = 2'd3
   } gb_reg_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   initial begin
      assert (STAGES >= 2) else $error("gpio_bank_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end

            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> stage_q[s] == $past(stage_q[s-1])); // R4
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH   = 7,
   parameter logic [WIDTH-1:0] DIR_RST = '1,
   parameter logic [WIDTH-1:0] OUT_RST = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [GB_ADDR_W-1:0] addr,
   input  logic                 wr,
   input  logic [WIDTH-1:0]     wdata,
   input  logic [WIDTH-1:0]     pin_val,
   output logic [WIDTH-1:0]     dir_q,
   output logic [WIDTH-1:0]     lat_q,
   output logic [WIDTH-1:0]     rdata
);

   gb_reg_e sel;
   logic    dir_we;
   logic    lat_we;

   assign sel    = gb_reg_e'(addr);
   assign dir_we = wr && (sel == GB_REG_DIR);
   assign lat_we = wr && ((sel == GB_REG_PIN) || (sel == GB_REG_OUT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= DIR_RST;
      else if (dir_we) dir_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= OUT_RST;
      else if (lat_we) lat_q <= wdata;
   end

   always_comb begin
      unique case (sel)
         GB_REG_DIR: rdata = dir_q;
         GB_REG_PIN: rdata = pin_val;
         GB_REG_OUT: rdata = lat_q;
         default:    rdata = '0;
      endcase
   end

   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == GB_REG_DIR) |=> dir_q == $past(wdata)); // R2

   AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (addr == GB_REG_PIN || addr == GB_REG_OUT)) |=> lat_q == $past(wdata)); // R3

   AST_SPARE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == GB_REG_NONE) |=> ($stable(dir_q) && $stable(lat_q))); // R9

endmodule

// File: rtl/gpio_bank_pins.sv
module gpio_bank_pins #(
   parameter int unsigned WIDTH     = 7,
   parameter int unsigned OD_BIT    = 4,
   parameter int unsigned GATED_BIT = 6
) (
   input  logic [WIDTH-1:0] dir,
   input  logic [WIDTH-1:0] lat,
   input  logic             osc_en,
   input  logic [WIDTH-1:0] ana_eff,
   input  logic [WIDTH-1:0] sync_in,
   output logic [WIDTH-1:0] oe,
   output logic [WIDTH-1:0] out,
   output logic [WIDTH-1:0] pin_val
);

   logic [WIDTH-1:0] gate;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         if (i == OD_BIT) begin : g_od
            assign oe[i]   = ~dir[i] & ~lat[i];
            assign out[i]  = 1'b0;
            assign gate[i] = 1'b1;
         end else if (i == GATED_BIT) begin : g_gated
            assign oe[i]   = ~dir[i] & osc_en;
            assign out[i]  = lat[i];
            assign gate[i] = osc_en;
         end else begin : g_plain
            assign oe[i]   = ~dir[i];
            assign out[i]  = lat[i];
            assign gate[i] = 1'b1;
         end
      end
   endgenerate

   assign pin_val = sync_in & ~ana_eff & gate;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH       = 7,
   parameter int unsigned OD_BIT      = 4,
   parameter int unsigned GATED_BIT   = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [GB_ADDR_W-1:0] bus_addr,
   input  logic                 bus_wr,
   input  logic [WIDTH-1:0]     bus_wdata,
   output logic [WIDTH-1:0]     bus_rdata,
   input  logic [WIDTH-1:0]     ana_sel,
   input  logic                 osc_io_en,
   input  logic [WIDTH-1:0]     pad_in,
   output logic [WIDTH-1:0]     pad_oe,
   output logic [WIDTH-1:0]     pad_out
);

   localparam logic [WIDTH-1:0] ONE_W       = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH-1:0] DIGITAL_FIX = (ONE_W << OD_BIT) | (ONE_W << GATED_BIT);

   initial begin
      assert (WIDTH >= 2) else $error("gpio_bank: WIDTH too small");
      assert (OD_BIT < WIDTH) else $error("gpio_bank: OD_BIT out of range");
      assert (GATED_BIT < WIDTH) else $error("gpio_bank: GATED_BIT out of range");
      assert (OD_BIT != GATED_BIT) else $error("gpio_bank: OD_BIT and GATED_BIT collide");
   end

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] pin_val;
   logic [WIDTH-1:0] ana_eff;

   assign ana_eff = ana_sel & ~DIGITAL_FIX;

   gpio_bank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pad_in),
      .d_out (pin_sync)
   );

   gpio_bank_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .pin_val (pin_val),
      .dir_q   (dir_q),
      .lat_q   (lat_q),
      .rdata   (bus_rdata)
   );

   gpio_bank_pins #(.WIDTH(WIDTH), .OD_BIT(OD_BIT), .GATED_BIT(GATED_BIT)) u_pins (
      .dir     (dir_q),
      .lat     (lat_q),
      .osc_en  (osc_io_en),
      .ana_eff (ana_eff),
      .sync_in (pin_sync),
      .oe      (pad_oe),
      .out     (pad_out),
      .pin_val (pin_val)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_chk
         AST_HIZ_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            dir_q[i] |-> !pad_oe[i]); // R5
      end
   endgenerate

   AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[OD_BIT] |-> (!pad_out[OD_BIT] && !lat_q[OD_BIT])); // R6

   AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_io_en |-> !pad_oe[GATED_BIT]); // R7

   AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == GB_REG_PIN) |-> ((bus_rdata & ana_eff) == '0)); // R8

endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [6:0] bus_wdata = '0;
   logic [6:0] bus_rdata;
   logic [6:0] ana_sel = 7'h2F;
   logic       osc_io_en = 1'b0;
   logic [6:0] pad_in = '0;
   logic [6:0] pad_oe;
   logic [6:0] pad_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   gpio_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_sel(ana_sel),
      .osc_io_en(osc_io_en), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [6:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [6:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [13:0] drive_model(input logic [6:0] d, input logic [6:0] l, input logic osc);
      logic [6:0] oe;
      logic [6:0] o;
      oe = ~d;
      o  = l;
      oe[4] = ~d[4] & ~l[4];
      o[4]  = 1'b0;
      oe[6] = ~d[6] & osc;
      return {oe, o};
   endfunction

   function automatic logic [6:0] read_model(input logic [6:0] p, input logic [6:0] m, input logic osc);
      logic [6:0] r;
      r = p & ~(m & 7'h2F);
      if (!osc) r[6] = 1'b0;
      return r;
   endfunction

   initial begin
      logic [6:0] rd;
      logic [6:0] ms [4];
      ms[0] = 7'h00; ms[1] = 7'h2F; ms[2] = 7'h7F; ms[3] = 7'h15;

      repeat (3) @(negedge clk);
      // R1: reset state
      bus_read(2'd0, rd); chk("R1 dir reset", 16'(rd), 16'h7F);
      bus_read(2'd2, rd); chk("R1 latch reset", 16'(rd), 16'h00);
      chk("R1 oe reset", 16'(pad_oe), 16'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(2'd0, rd); chk("R1 dir after release", 16'(rd), 16'h7F);
      chk("R1 oe after release", 16'(pad_oe), 16'h00);

      // R2 R3 R5 R6 R7 R8: sweep every direction/latch pair, analog mask held at 7'h2F
      ana_sel = 7'h2F;
      for (int d = 0; d < 128; d++) begin
         osc_io_en = d[0];
         bus_write(2'd0, 7'(d));
         bus_read(2'd0, rd); chk("R2 dir readback", 16'(rd), 16'(d));
         for (int l = 0; l < 128; l++) begin
            bus_write((l % 2 == 1) ? 2'd1 : 2'd2, 7'(l));
            chk("R5 R6 R7 R8 drive", 16'({pad_oe, pad_out}), 16'(drive_model(7'(d), 7'(l), d[0])));
         end
      end

      // R3: latch readback ignores pad levels
      bus_write(2'd0, 7'h7F);
      pad_in = 7'h7F;
      bus_write(2'd1, 7'h12);
      repeat (2) @(negedge clk);
      bus_read(2'd2, rd); chk("R3 latch not pins", 16'(rd), 16'h12);
      bus_write(2'd2, 7'h6D);
      bus_read(2'd2, rd); chk("R3 latch via addr2", 16'(rd), 16'h6D);

      // R4: synchronizer latency
      ana_sel = 7'h00; osc_io_en = 1'b1;
      @(negedge clk); pad_in = 7'h00;
      repeat (2) @(negedge clk);
      pad_in = 7'h55;
      @(negedge clk);
      bus_read(2'd1, rd); chk("R4 one edge old", 16'(rd), 16'h00);
      @(negedge clk);
      bus_read(2'd1, rd); chk("R4 two edges new", 16'(rd), 16'h55);

      // R4 R7 R8: pin view sweep across masks and mode
      for (int k = 0; k < 8; k++) begin
         for (int p = 0; p < 128; p++) begin
            @(negedge clk);
            pad_in    = 7'(p);
            ana_sel   = ms[k % 4];
            osc_io_en = (k >= 4);
            repeat (2) @(negedge clk);
            bus_read(2'd1, rd);
            chk("R4 R7 R8 pin view", 16'(rd), 16'(read_model(7'(p), ms[k % 4], k >= 4)));
         end
      end

      // R9: spare address
      bus_write(2'd0, 7'h55);
      bus_write(2'd2, 7'h2A);
      bus_write(2'd3, 7'h7F);
      bus_read(2'd3, rd); chk("R9 spare reads 0", 16'(rd), 16'h00);
      bus_read(2'd0, rd); chk("R9 dir untouched", 16'(rd), 16'h55);
      bus_read(2'd2, rd); chk("R9 latch untouched", 16'(rd), 16'h2A);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule